// File: doc/BRIEF.md
# Nine-Bit Addressed Serial Receiver

This block receives asynchronous serial frames whose payload is nine bits wide, for a shared link where one master talks to many slaves. The ninth payload bit tags each word. When it is set, the word is an address and its low eight bits are compared with the slave's own address. When it is clear, the word is data for whichever slave the last address word selected. Only data that follows an address match reaches the output. Every other data word is discarded without a trace at the ports.

The line is oversampled with an external tick that runs at sixteen times the bit rate. A frame is one low start bit, nine payload bits sent least significant bit first, and one high stop bit. The start bit is checked again half a bit period after the falling edge, so short low glitches are rejected. A low stop bit raises a one-cycle framing-error pulse and the frame is thrown away. Address value 0xFF is accepted by every slave as a broadcast. The transmitter, the tick generator and any command parsing are outside this block.

Top module: `mp9_rx`

## Requirements
- R1: A frame is a low start bit, nine payload bits least significant first, and a high stop bit, each sixteen ticks long. Payload bits 0..7 form the byte and bit 8 is the address tag.
- R2: The start bit is checked again eight ticks after the falling edge. If the line is high at that point, the event is dropped and produces no output.
- R3: A frame with tag 1 and a high stop bit sets `addr_match_o` to 1 when its byte equals `own_addr_i`, and clears it otherwise. It never pulses `data_valid_o`.
- R4: An address byte of 0xFF sets `addr_match_o` whatever the value of `own_addr_i`.
- R5: A frame with tag 0 and a high stop bit, received while `addr_match_o` is 1, puts its byte on `data_o` with `data_valid_o` high for exactly one clock. While `addr_match_o` is 0, such a frame leaves `data_o` unchanged and gives no strobe.
- R6: Every valid address frame evaluates the match again, including when `addr_match_o` is already 1.
- R7: A frame whose stop bit is low pulses `frame_err_o` for one clock. It changes neither `data_o` nor `addr_match_o`. The receiver then waits for the line to go high before it looks for the next start bit.
- R8: After reset, `addr_match_o`, `data_valid_o`, `frame_err_o` and `data_o` are all 0, so no data is delivered until an address matches.
- R9: A change of `own_addr_i` on its own does not change `addr_match_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high, asynchronous to clk |
| tick_i | input | 1 | One-clock strobe at 16x the bit rate |
| own_addr_i | input | 8 | This slave's address |
| data_o | output | 8 | Last delivered data byte |
| data_valid_o | output | 1 | One-clock strobe for each delivered byte |
| addr_match_o | output | 1 | Result of the last valid address frame |
| frame_err_o | output | 1 | One-clock strobe when a stop bit is low |

## Verification
A bad bit counter or a wrongly sampled bit corrupts the whole frame. The error shows at the ports about one frame later: either a wrong byte on `data_o`, or a wrong match state that then lets through, or drops, the next data byte. A match flag stuck in the wrong state is subtler, because nothing shows until the next data frame arrives. For that reason the stimulus follows each address with data frames, and it changes `own_addr_i` between frames. After a framing error, a receiver that does not wait for the line to go high would misread the rest of the low stop bit as a new start. The check that follows the error frame catches this.

// File: rtl/mp9_pkg.sv
// Shared types for the nine-bit addressed receiver.
package mp9_pkg;
    // Receiver frame-walk states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP,
        ST_WAIT_HI
    } rx_state_t;
endpackage

// File: rtl/mp9_sync.sv
// Two-flop synchronizer for the asynchronous serial line.
// Assumes: the line idles high, so the flops reset to 1.
module mp9_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mp9_framer.sv
// Walks one serial frame with the oversampling tick. It confirms the start
// bit at mid-bit, samples each payload bit and the stop bit at mid-bit, and
// presents the word for one clock.
// Assumes: rx_i is already synchronized; tick_i is a single-clock strobe.
module mp9_framer
    import mp9_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int NBITS  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             tick_i,
    output logic             done_o,
    output logic             stop_ok_o,
    output logic [NBITS-1:0] word_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(NBITS + 1);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(NBITS - 1);

    rx_state_t        state;
    logic [CNT_W-1:0] tcnt;
    logic [IDX_W-1:0] idx;
    logic [NBITS-1:0] shreg;

    // Frame state machine with tick counter and payload shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            idx       <= '0;
            shreg     <= '0;
            done_o    <= 1'b0;
            stop_ok_o <= 1'b0;
            word_o    <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    tcnt <= '0;
                    if (!rx_i) state <= ST_START;
                end
                ST_START: begin
                    if (tick_i) begin
                        if (tcnt == HALF_M1) begin
                            tcnt  <= '0;
                            idx   <= '0;
                            state <= rx_i ? ST_IDLE : ST_BITS;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                ST_BITS: begin
                    if (tick_i) begin
                        if (tcnt == FULL_M1) begin
                            tcnt  <= '0;
                            shreg <= {rx_i, shreg[NBITS-1:1]};
                            if (idx == LAST) state <= ST_STOP;
                            else             idx   <= idx + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick_i) begin
                        if (tcnt == FULL_M1) begin
                            tcnt      <= '0;
                            done_o    <= 1'b1;
                            stop_ok_o <= rx_i;
                            word_o    <= shreg;
                            state     <= rx_i ? ST_IDLE : ST_WAIT_HI;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                ST_WAIT_HI: begin
                    if (rx_i) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mp9_filter.sv
// Address filter. An address word updates the match flag. A data word
// passes to the output only while the flag is set. A bad stop bit gives an
// error strobe and nothing else.
// Assumes: done_i is a one-clock strobe with word_i and stop_ok_i valid.
module mp9_filter #(
    parameter int                DW    = 8,
    parameter logic [DW-1:0]     BCAST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic          stop_ok_i,
    input  logic [DW:0]   word_i,
    input  logic [DW-1:0] own_addr_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o,
    output logic          match_o,
    output logic          err_o
);
    logic          is_addr;
    logic [DW-1:0] payload;
    logic          hit;

    // Split the word and decide whether an address selects this slave
    always_comb begin
        is_addr = word_i[DW];
        payload = word_i[DW-1:0];
        hit     = (payload == own_addr_i) || (payload == BCAST);
    end

    // Update match state, deliver data, flag framing errors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            match_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            if (done_i) begin
                if (!stop_ok_i) begin
                    err_o <= 1'b1;
                end else if (is_addr) begin
                    match_o <= hit;
                end else if (match_o) begin
                    data_o  <= payload;
                    valid_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mp9_rx.sv
// Top of the nine-bit addressed serial receiver: synchronizer, frame walker
// and address filter in series.
// Assumes: tick_i strobes at OSR times the bit rate.
module mp9_rx #(
    parameter int            DW    = 8,
    parameter int            OSR   = 16,
    parameter logic [DW-1:0] BCAST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_i,
    input  logic          tick_i,
    input  logic [DW-1:0] own_addr_i,
    output logic [DW-1:0] data_o,
    output logic          data_valid_o,
    output logic          addr_match_o,
    output logic          frame_err_o
);
    localparam int NBITS = DW + 1;

    logic             rx_s;
    logic             fr_done;
    logic             fr_stop_ok;
    logic [NBITS-1:0] fr_word;

    mp9_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    mp9_framer #(.OSR(OSR), .NBITS(NBITS)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_i      (rx_s),
        .tick_i    (tick_i),
        .done_o    (fr_done),
        .stop_ok_o (fr_stop_ok),
        .word_o    (fr_word)
    );

    mp9_filter #(.DW(DW), .BCAST(BCAST)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (fr_done),
        .stop_ok_i  (fr_stop_ok),
        .word_i     (fr_word),
        .own_addr_i (own_addr_i),
        .data_o     (data_o),
        .valid_o    (data_valid_o),
        .match_o    (addr_match_o),
        .err_o      (frame_err_o)
    );
endmodule

// File: rtl/mp9_rx_chk.sv
// Property checker for mp9_rx, attached by bind. It watches the ports and
// the framer-to-filter handoff.
module mp9_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] data_o,
    input logic          data_valid_o,
    input logic          addr_match_o,
    input logic          frame_err_o,
    input logic          fr_done,
    input logic          fr_stop_ok,
    input logic [DW:0]   fr_word
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |=> !data_valid_o);                                    // R5
    AST_VALID_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> addr_match_o);                                     // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid_o |-> $stable(data_o));                                 // R5
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);                                      // R7
    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> !data_valid_o);                                     // R7
    AST_MATCH_ON_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_match_o) |-> $past(fr_done && fr_stop_ok && fr_word[DW])); // R6
    AST_ADDR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && fr_word[DW]) |=> !data_valid_o);                        // R3
endmodule

bind mp9_rx mp9_rx_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_o       (data_o),
    .data_valid_o (data_valid_o),
    .addr_match_o (addr_match_o),
    .frame_err_o  (frame_err_o),
    .fr_done      (fr_done),
    .fr_stop_ok   (fr_stop_ok),
    .fr_word      (fr_word)
);

// File: tb/mp9_rx_bench.sv
module mp9_rx_bench;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;
    // Vector: {tag, byte[7:0], stop, exp_strobe, exp_data[7:0], exp_match, exp_err}
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'h11, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R8 data before any match
        {1'b1, 8'h33, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R3 foreign address
        {1'b0, 8'h22, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 dropped
        {1'b1, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0}, // R3 own address, no strobe
        {1'b0, 8'hC3, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b0}, // R1 R5 delivered
        {1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0}, // R5 delivered
        {1'b1, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0}, // R6 re-match while matched
        {1'b1, 8'h5B, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}, // R7 bad stop, match kept
        {1'b0, 8'h7E, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}, // R7 bad stop, data kept
        {1'b0, 8'h81, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0}, // R7 recovered after error
        {1'b1, 8'h5B, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0}, // R6 leave match
        {1'b0, 8'h44, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0}, // R5 dropped, data held
        {1'b1, 8'hFF, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0}, // R4 broadcast
        {1'b0, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0}  // R1 R4 delivered
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] own = 8'h5A;
    logic [7:0] data_o;
    logic       data_valid_o, addr_match_o, frame_err_o;

    int checks = 0, errors = 0;
    int vcnt = 0, ecnt = 0, tdiv = 0;
    logic prev_v = 1'b0, prev_e = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    mp9_rx u_mp9_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .own_addr_i(own),
        .data_o(data_o), .data_valid_o(data_valid_o),
        .addr_match_o(addr_match_o), .frame_err_o(frame_err_o)
    );

    // Tick generator and strobe monitor, both away from the rising edge
    always @(negedge clk) begin
        tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == TICK_DIV - 1);
        if (rst_n) begin
            if (data_valid_o) vcnt <= vcnt + 1;
            if (frame_err_o)  ecnt <= ecnt + 1;
            if (prev_v && data_valid_o) begin
                errors++; $display("FAIL R5 strobe wider than one cycle act=2 exp=1");
            end
            if (prev_e && frame_err_o) begin
                errors++; $display("FAIL R7 error strobe wider than one cycle act=2 exp=1");
            end
        end
        prev_v <= data_valid_o;
        prev_e <= frame_err_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send(input logic tag, input logic [7:0] b, input logic stop);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        hold_bit(tag);
        hold_bit(stop);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v0, e0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 match after reset", addr_match_o, 0);
        chk("R8 data after reset", data_o, 0);
        chk("R8 strobe after reset", data_valid_o, 0);
        chk("R8 error after reset", frame_err_o, 0);

        for (int k = 0; k < NV; k++) begin
            logic [20:0] v;
            v = VEC[k];
            v0 = vcnt; e0 = ecnt;
            send(v[20], v[19:12], v[11]);
            chk($sformatf("R5 vec%0d strobe count", k), vcnt - v0, int'(v[10]));
            chk($sformatf("R1 vec%0d data", k), data_o, v[9:2]);
            chk($sformatf("R3 vec%0d match", k), addr_match_o, v[1]);
            chk($sformatf("R7 vec%0d error count", k), ecnt - e0, int'(v[0]));
        end

        // R2: short low glitch is rejected
        v0 = vcnt; e0 = ecnt;
        @(negedge clk); rx = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rx = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R2 glitch strobe", vcnt - v0, 0);
        chk("R2 glitch error", ecnt - e0, 0);
        chk("R2 glitch data", data_o, 8'hA5);
        send(1'b0, 8'h3C, 1'b1);
        chk("R2 frame after glitch strobe", vcnt - v0, 1);
        chk("R2 frame after glitch data", data_o, 8'h3C);

        // R9: own address change alone keeps the match state
        own = 8'h10;
        repeat (20) @(negedge clk);
        chk("R9 match after own change", addr_match_o, 1);
        send(1'b1, 8'h5A, 1'b1);
        chk("R9 old address no longer matches", addr_match_o, 0);
        send(1'b1, 8'h10, 1'b1);
        chk("R9 new address matches", addr_match_o, 1);
        v0 = vcnt;
        send(1'b0, 8'h96, 1'b1);
        chk("R9 data under new address", data_o, 8'h96);
        chk("R9 strobe under new address", vcnt - v0, 1);

        // R8: reset clears the match mid-session
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 match cleared by reset", addr_match_o, 0);
        chk("R8 data cleared by reset", data_o, 0);
        v0 = vcnt;
        send(1'b0, 8'h55, 1'b1);
        chk("R8 no delivery before match", vcnt - v0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule